// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block sits on the host side of a three-wire, read-only serial link to a power-managed sampling converter. The link has an active-low chip select, a serial clock and a single data input. Commands arrive over a valid/ready handshake. A read command runs a full sixteen-clock frame. It drops the four leading bits and returns the twelve-bit sample over a second valid/ready handshake. Two other commands manage the converter's power. A sleep command runs a deliberately short frame, and raising chip select early in that frame shuts the converter down. A wake command runs a full dummy frame and throws its data away.

The sequencer tracks whether the converter is awake. After reset the converter's state is unknown, so it starts as asleep. A read issued while the converter is asleep first runs a dummy wake frame. The read frame is then held back until a programmable power-up interval has passed since the wake frame started. The same interval applies after an explicit wake command. Between any two frames, chip select stays high for a programmable quiet interval. The serial clock is the system clock divided by a parameter.

Top module: `adc_host_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, `cs_n`=1, `sclk`=1, `busy`=0, `cmd_ready`=1 and `rsp_valid`=0. The converter is taken to be asleep.
- R2: `sclk` is high whenever `cs_n` is high. The first falling edge of `sclk` comes CLK_HALF cycles after `cs_n` falls. Later falling edges are 2*CLK_HALF cycles apart. Data is sampled on the rising edge.
- R3: A read frame has exactly 16 falling `sclk` edges. The 16 bits arrive MSB first. `rsp_data` is the last 12 bits, and the first 4 bits are discarded even when they are not zero.
- R4: Opcode 2'b01 (sleep) produces a frame of SLEEP_EDGES falling edges (default 5, legal 2 to 9). `cs_n` rises before the next falling edge, and no response is produced.
- R5: Opcode 2'b10 (wake) produces a full 16-edge frame whose data is discarded. No response is produced.
- R6: Opcode 2'b00 (read) issued after reset or after a sleep runs two 16-edge frames, a dummy frame and then the read. Only the second frame's data is returned.
- R7: A read frame's `cs_n` falling edge comes at least PWRUP_CYC cycles after the most recent wake frame's `cs_n` falling edge.
- R8: `cs_n` stays high for at least QUIET_CYC cycles between the end of one frame and the start of the next.
- R9: `cmd_ready` is high only while the sequencer is idle. `rsp_valid` and `rsp_data` hold until `rsp_ready` is seen. No command is accepted while a response is pending.
- R10: `busy` is high whenever `cs_n` is low, and during the quiet and power-up waits that follow a frame.
- R11: Opcode 2'b11 is accepted and ignored. It starts no frame and produces no response.
- R12: A read issued while the converter is awake runs a single 16-edge frame with no dummy frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | Opcode: 00 read, 01 sleep, 10 wake, 11 no operation |
| cmd_ready | output | 1 | Command accepted when high together with `cmd_valid` |
| rsp_valid | output | 1 | Read result available |
| rsp_data | output | DATA_W (12) | Conversion result |
| rsp_ready | input | 1 | Consumer takes the result |
| busy | output | 1 | A frame, quiet wait or power-up wait is in progress |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sdata | input | 1 | Serial data from the converter |

## Verification
Several rules are checked on every cycle by the in-line assertions. These are the clock idling high under a raised chip select, `busy` covering every low chip select, the response staying stable while it waits, and frame starts arriving only from idle. Two timing rules are checked with counters that run alongside the datapath: the quiet gap before each frame start, and the power-up interval before each read frame. The bench scenarios are needed for everything that depends on content and counts. These are the number of frames per command, the edge count of short and full frames, the discarding of leading bits, the dropped dummy data, and the dummy frame coming back after a reset in mid-frame.

// File: rtl/adc_host_pkg.sv
// Package: shared types for the serial ADC host sequencer.
// Assumes: opcode encoding is fixed by the command interface (00 read,
// 01 sleep, 10 wake, 11 no operation).
package adc_host_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_SLEEP = 2'b01,
        OP_WAKE  = 2'b10,
        OP_NONE  = 2'b11
    } adc_op_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FRAME,
        S_QUIET,
        S_PUWAIT,
        S_RESP
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH
    } frame_phase_t;

endpackage

// File: rtl/adc_wait_timer.sv
// Module: down-counting wait timer.
// Loading sets the count; it then falls by one each cycle to zero.
// Assumes: load_val >= 1 when a wait is wanted; done is high at zero.
module adc_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/adc_frame_engine.sv
// Module: serial frame engine.
// On start it lowers chip select and emits n_edges serial clock periods.
// Each period is a falling edge followed by a rising edge that samples
// sdata into a shift register. Chip select is then raised and done is pulsed.
// Assumes: start only arrives while idle; CLK_HALF >= 1; n_edges >= 1.
module adc_frame_engine
    import adc_host_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int CLK_HALF   = 2,
    parameter int EDGE_W     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [EDGE_W-1:0]     n_edges,
    input  logic                  sdata,
    output logic                  cs_n,
    output logic                  sclk,
    output logic                  done,
    output logic [FRAME_BITS-1:0] word
);

    localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

    frame_phase_t           phase;
    logic [DW-1:0]          cnt;
    logic [EDGE_W-1:0]      edges;
    logic [EDGE_W-1:0]      target;
    logic                   tick;

    assign tick = (cnt == DW'(CLK_HALF - 1));

    // Phase sequencer: lead-in, low half, high half, repeated per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            edges  <= '0;
            target <= '0;
            cs_n   <= 1'b1;
            sclk   <= 1'b1;
            done   <= 1'b0;
            word   <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cs_n   <= 1'b0;
                        target <= n_edges;
                        edges  <= '0;
                        cnt    <= '0;
                        phase  <= PH_LEAD;
                    end
                end
                PH_LEAD: begin
                    if (tick) begin
                        cnt   <= '0;
                        sclk  <= 1'b0;
                        edges <= edges + 1'b1;
                        phase <= PH_LOW;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        cnt   <= '0;
                        sclk  <= 1'b1;
                        word  <= {word[FRAME_BITS-2:0], sdata};
                        phase <= PH_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        cnt <= '0;
                        if (edges == target) begin
                            cs_n  <= 1'b1;
                            done  <= 1'b1;
                            phase <= PH_IDLE;
                        end else begin
                            sclk  <= 1'b0;
                            edges <= edges + 1'b1;
                            phase <= PH_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: clock never low while the converter is deselected.
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R10: the sequencer only requests a frame when the engine is free.
    p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase == PH_IDLE));

endmodule

// File: rtl/adc_host_ctrl.sv
// Module: host sequencer for a power-managed serial ADC.
// Accepts read/sleep/wake commands, runs the matching frame, tracks the
// converter's power state, and enforces quiet and power-up intervals.
// Assumes: SLEEP_EDGES in 2..9; QUIET_CYC >= 1; PWRUP_CYC >= 1;
// the converter drives sdata after each falling sclk edge.
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int LEAD_BITS   = 4,
    parameter int CLK_HALF    = 2,
    parameter int SLEEP_EDGES = 5,
    parameter int QUIET_CYC   = 3,
    parameter int PWRUP_CYC   = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_ready,
    output logic              busy,
    output logic              cs_n,
    output logic              sclk,
    input  logic              sdata
);

    localparam int FRAME_BITS = LEAD_BITS + DATA_W;
    localparam int EDGE_W     = $clog2(FRAME_BITS + 1);
    localparam int PU_W       = $clog2(PWRUP_CYC + 1);
    localparam int Q_W        = $clog2(QUIET_CYC + 1);

    seq_state_t              state;
    adc_op_t                 kind;
    adc_op_t                 op_in;
    logic                    go;
    logic                    awake;
    logic                    pend_read;
    logic                    fr_done;
    logic [FRAME_BITS-1:0]   fr_word;
    logic [EDGE_W-1:0]       n_edges;
    logic                    q_load;
    logic                    q_done;
    logic                    pu_load;
    logic                    pu_done;

    assign op_in   = adc_op_t'(cmd_op);
    assign n_edges = (kind == OP_SLEEP) ? EDGE_W'(SLEEP_EDGES) : EDGE_W'(FRAME_BITS);
    assign q_load  = (state == S_FRAME) && fr_done;
    assign pu_load = go && (kind == OP_WAKE);

    assign cmd_ready = (state == S_IDLE);
    assign busy      = (state == S_FRAME) || (state == S_QUIET) || (state == S_PUWAIT);

    adc_frame_engine #(
        .FRAME_BITS (FRAME_BITS),
        .CLK_HALF   (CLK_HALF),
        .EDGE_W     (EDGE_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (go),
        .n_edges (n_edges),
        .sdata   (sdata),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .done    (fr_done),
        .word    (fr_word)
    );

    adc_wait_timer #(.W(Q_W)) u_quiet (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (q_load),
        .load_val (Q_W'(QUIET_CYC)),
        .done     (q_done)
    );

    adc_wait_timer #(.W(PU_W)) u_pwrup (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pu_load),
        .load_val (PU_W'(PWRUP_CYC)),
        .done     (pu_done)
    );

    // Command sequencer: frame choice, power tracking, waits and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            kind      <= OP_NONE;
            go        <= 1'b0;
            awake     <= 1'b0;
            pend_read <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            go <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        case (op_in)
                            OP_READ: begin
                                pend_read <= 1'b1;
                                if (!awake) begin
                                    kind  <= OP_WAKE;
                                    go    <= 1'b1;
                                    state <= S_FRAME;
                                end else begin
                                    state <= S_PUWAIT;
                                end
                            end
                            OP_SLEEP, OP_WAKE: begin
                                kind  <= op_in;
                                go    <= 1'b1;
                                state <= S_FRAME;
                            end
                            default: state <= S_IDLE;
                        endcase
                    end
                end
                S_FRAME: begin
                    if (fr_done) begin
                        if (kind == OP_WAKE)  awake <= 1'b1;
                        if (kind == OP_SLEEP) awake <= 1'b0;
                        if (kind == OP_READ)  rsp_data <= fr_word[DATA_W-1:0];
                        state <= S_QUIET;
                    end
                end
                S_QUIET: begin
                    if (q_done) begin
                        if (pend_read) begin
                            state <= S_PUWAIT;
                        end else if (kind == OP_READ) begin
                            rsp_valid <= 1'b1;
                            state     <= S_RESP;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                S_PUWAIT: begin
                    if (pu_done) begin
                        kind      <= OP_READ;
                        pend_read <= 1'b0;
                        go        <= 1'b1;
                        state     <= S_FRAME;
                    end
                end
                S_RESP: begin
                    if (rsp_ready) begin
                        rsp_valid <= 1'b0;
                        state     <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Checker counter: cycles chip select has been high, saturating.
    logic [Q_W-1:0] qh_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                          qh_cnt <= Q_W'(QUIET_CYC);
        else if (!cs_n)                      qh_cnt <= '0;
        else if (qh_cnt < Q_W'(QUIET_CYC))   qh_cnt <= qh_cnt + 1'b1;
    end

    // Checker counter: cycles since the last wake frame was launched.
    logic [PU_W-1:0] sw_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                          sw_cnt <= '0;
        else if (go && kind == OP_WAKE)      sw_cnt <= '0;
        else if (sw_cnt < PU_W'(PWRUP_CYC))  sw_cnt <= sw_cnt + 1'b1;
    end

    // R8: a frame launches only after the full quiet interval.
    p_quiet_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (qh_cnt >= Q_W'(QUIET_CYC)));

    // R7: a read frame launches only after the power-up interval.
    p_pwrup_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && kind == OP_READ) |-> (sw_cnt >= PU_W'(PWRUP_CYC)));

    // R9: a pending response holds until taken.
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R9: never ready for a command while a response waits.
    p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    // R10: busy covers every active chip select.
    p_busy_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

endmodule

// File: tb/adc_host_ctrl_tb.sv
module adc_host_ctrl_tb;

    localparam int DATA_W    = 12;
    localparam int CLK_HALF  = 2;
    localparam int SLEEP_E   = 5;
    localparam int QUIET     = 6;
    localparam int PWRUP     = 100;
    localparam int NVEC      = 11;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] word;
        logic [1:0]  nfr;
        logic [4:0]  edges;
        logic        rsp;
        logic [11:0] data;
        logic        chk_pu;
    } vec_t;

    // op, converter word, frames, edges per frame, response, data, power-up check
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 16'h0ABC, 2'd2, 5'd16, 1'b1, 12'hABC, 1'b1},  // R6 R3 R7 first read after reset
        '{2'd0, 16'hF123, 2'd1, 5'd16, 1'b1, 12'h123, 1'b0},  // R3 R12 leading ones dropped
        '{2'd1, 16'h0000, 2'd1, 5'd5,  1'b0, 12'h000, 1'b0},  // R4 sleep
        '{2'd0, 16'h0FFF, 2'd2, 5'd16, 1'b1, 12'hFFF, 1'b1},  // R6 read after sleep
        '{2'd2, 16'hA5A5, 2'd1, 5'd16, 1'b0, 12'h000, 1'b0},  // R5 wake
        '{2'd0, 16'h0000, 2'd1, 5'd16, 1'b1, 12'h000, 1'b1},  // R7 R12 read soon after wake
        '{2'd3, 16'h0000, 2'd0, 5'd0,  1'b0, 12'h000, 1'b0},  // R11 no-op
        '{2'd0, 16'h8555, 2'd1, 5'd16, 1'b1, 12'h555, 1'b0},  // R3 R12
        '{2'd1, 16'h0000, 2'd1, 5'd5,  1'b0, 12'h000, 1'b0},  // R4
        '{2'd1, 16'h0000, 2'd1, 5'd5,  1'b0, 12'h000, 1'b0},  // R4 R8 back-to-back
        '{2'd0, 16'h0321, 2'd2, 5'd16, 1'b1, 12'h321, 1'b1}   // R6
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b11;
    logic              cmd_ready;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_ready = 1'b0;
    logic              busy;
    logic              cs_n;
    logic              sclk;
    logic              sdata = 1'b0;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_host_ctrl #(
        .DATA_W      (DATA_W),
        .LEAD_BITS   (4),
        .CLK_HALF    (CLK_HALF),
        .SLEEP_EDGES (SLEEP_E),
        .QUIET_CYC   (QUIET),
        .PWRUP_CYC   (PWRUP)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_ready (rsp_ready),
        .busy      (busy),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdata     (sdata)
    );

    // Converter model and frame monitor, all at the falling system clock.
    logic [15:0] adc_word = 16'h0;
    int cyc = 0;
    int nfr = 0;
    int fstart [256];
    int fedges [256];
    int falls = 0;
    int bit_idx = 0;
    int last_fall = 0;
    int last_rise = 0;
    bit have_rise = 1'b0;
    int min_gap = 1000000;
    int viol_r2 = 0;
    int viol_r10 = 0;
    logic p_cs = 1'b1;
    logic p_sclk = 1'b1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cs_n && !sclk) viol_r2 = viol_r2 + 1;
        if (rst_n && !cs_n && !busy) viol_r10 = viol_r10 + 1;
        if (p_cs && !cs_n) begin
            if (nfr < 256) fstart[nfr] = cyc;
            falls = 0;
            bit_idx = 0;
            if (have_rise && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
        end
        if (p_sclk && !sclk && !cs_n) begin
            if (falls == 0) begin
                if (cyc - fstart[nfr] != CLK_HALF) viol_r2 = viol_r2 + 1;
            end else if (cyc - last_fall != 2 * CLK_HALF) begin
                viol_r2 = viol_r2 + 1;
            end
            last_fall = cyc;
            falls = falls + 1;
            sdata <= adc_word[15 - (bit_idx % 16)];
            bit_idx = bit_idx + 1;
        end
        if (!p_cs && cs_n) begin
            if (nfr < 256) fedges[nfr] = falls;
            nfr = nfr + 1;
            last_rise = cyc;
            have_rise = 1'b1;
        end
        p_cs = cs_n;
        p_sclk = sclk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Issue one command and wait for either its response or a return to idle.
    task automatic run_cmd(input logic [1:0] op, input logic [15:0] word,
                           output bit got, output logic [11:0] data, output int frames);
        int n0;
        got = 1'b0;
        data = '0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        n0 = nfr;
        adc_word = word;
        cmd_op = op;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (rsp_valid) begin
                got = 1'b1;
                data = rsp_data;
                break;
            end
            if (cmd_ready && !busy) break;
            @(negedge clk);
        end
        frames = nfr - n0;
        if (got) begin
            chk(cmd_ready == 1'b0, "R9 ready low with response", cmd_ready, 0);
            cmd_valid = 1'b1;
            cmd_op = 2'b01;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(rsp_valid && rsp_data == data, "R9 response held", rsp_data, data);
            end
            cmd_valid = 1'b0;
            chk(nfr - n0 == frames, "R9 no command while response pending", nfr - n0, frames);
            rsp_ready = 1'b1;
            @(negedge clk);
            rsp_ready = 1'b0;
            chk(!rsp_valid && cmd_ready, "R9 response released", rsp_valid, 0);
        end
    endtask

    initial begin
        bit got;
        logic [11:0] data;
        int frames;
        int n0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(cs_n && sclk && !busy && cmd_ready && !rsp_valid, "R1 reset outputs",
            {cs_n, sclk, busy, cmd_ready, rsp_valid}, 5'b11010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_cmd(VECS[v].op, VECS[v].word, got, data, frames);
            chk(frames == int'(VECS[v].nfr), $sformatf("R6 R11 R12 frame count v%0d", v),
                frames, VECS[v].nfr);
            for (int f = 0; f < frames; f++)
                chk(fedges[nfr - frames + f] == int'(VECS[v].edges),
                    $sformatf("R3 R4 R5 edge count v%0d", v), fedges[nfr - frames + f], VECS[v].edges);
            chk(got == VECS[v].rsp, $sformatf("R4 R5 R11 response presence v%0d", v), got, VECS[v].rsp);
            if (VECS[v].rsp)
                chk(data == VECS[v].data, $sformatf("R3 result v%0d", v), data, VECS[v].data);
            if (VECS[v].chk_pu)
                chk(fstart[nfr - 1] - fstart[nfr - 2] >= PWRUP, $sformatf("R7 power-up gap v%0d", v),
                    fstart[nfr - 1] - fstart[nfr - 2], PWRUP);
        end

        // Reset in the middle of a read frame; the converter is then unknown again.
        @(negedge clk);
        adc_word = 16'h0777;
        cmd_op = 2'b00;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (cs_n) @(negedge clk);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(cs_n && sclk && !busy && cmd_ready && !rsp_valid, "R1 mid-frame reset outputs",
            {cs_n, sclk, busy, cmd_ready, rsp_valid}, 5'b11010);
        rst_n = 1'b1;
        n0 = nfr;
        run_cmd(2'b00, 16'h0246, got, data, frames);
        chk(frames == 2, "R6 dummy frame after reset", frames, 2);
        chk(got && data == 12'h246, "R3 R6 result after reset", data, 12'h246);

        // Monitor summaries.
        chk(viol_r2 == 0, "R2 serial clock shape", viol_r2, 0);
        chk(viol_r10 == 0, "R10 busy during frame", viol_r10, 0);
        chk(min_gap >= QUIET, "R8 quiet gap", min_gap, QUIET);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule